// File: doc/BRIEF.md
# T1 Extended-Superframe CRC-6 Checker

This block verifies the cyclic redundancy check carried inside a received T1 extended-superframe bit stream. An upstream frame synchronizer delivers one received bit per strobe, together with a pulse that marks the first bit of each 24-frame multiframe and a flag that marks the framing-bit slot of each frame. From this stream the block computes a CRC-6 remainder over every multiframe. It also collects the six check bits that the transmitter placed in selected framing-bit slots.

A multiframe's check bits describe the multiframe sent before it. The block therefore holds each finished remainder for one multiframe. At the next multiframe boundary it compares that remainder with the check bits just collected. Any difference produces a one-cycle error pulse and adds one count to a saturating error counter. Software-side logic reads the counter through a snapshot strobe. The strobe copies the count to a stable output register and restarts the live count from zero in the same cycle.

Checking runs only while the stream is synchronized, checking is enabled, and the configured multiframe format carries CRC bits. Leaving that state discards all CRC history.

Top module: `t1_crc6_mf_check`

## Requirements
- R1: The remainder of a multiframe is the CRC-6 with generator x^6 + x + 1 (zero initial state), taken over every accepted bit of the multiframe in arrival order. Each framing-bit slot counts as a 1 whatever its received value. The coefficient of x^5 is compared with the first collected check bit, and so on down to x^0 with the sixth.
- R2: Frames are numbered 1 to 24 from the multiframe start pulse. The check bits are the framing-bit slots of frames 2, 6, 10, 14, 18 and 22, in that order. The other framing bits have no effect on any comparison.
- R3: At each multiframe boundary with a comparison due, `crc_err` is high for exactly the one cycle after the start bit is accepted if the held remainder differs from the collected check bits in one or more positions. Any number of differing bits adds exactly one count.
- R4: After checking becomes active, the first two multiframe boundaries make no comparison. The first comparison is made at the third boundary, between the first complete multiframe's remainder and the second multiframe's check bits.
- R5: While `in_sync`, `chk_en` or `crc_fmt` is low, no error pulse is raised and nothing is counted. All held remainder and frame-position state is discarded, so a later activation starts again as in R4.
- R6: While `bit_vld` is low, `bit_in`, `mf_start` and `fslot` have no effect.
- R7: The live error count is CNT_W bits wide (default 16). It stops at all ones (2^CNT_W - 1) instead of wrapping.
- R8: A cycle with `snap` high loads `err_cnt_q` on that clock edge with the live count plus any increment from the same cycle. The live count becomes zero. `err_cnt_q` changes at no other time.
- R9: After reset `crc_err` is 0 and `err_cnt_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sync | input | 1 | Upstream synchronizer holds multiframe alignment |
| chk_en | input | 1 | CRC checking enabled |
| crc_fmt | input | 1 | Selected multiframe format carries CRC bits |
| bit_vld | input | 1 | Strobe: the other stream inputs carry a bit this cycle |
| bit_in | input | 1 | Received data bit |
| mf_start | input | 1 | This bit is the first bit (framing slot of frame 1) of a multiframe |
| fslot | input | 1 | This bit is a framing-bit slot |
| snap | input | 1 | Snapshot the error count and clear the live count |
| crc_err | output | 1 | One-cycle pulse on a CRC mismatch |
| err_cnt_q | output | CNT_W | Error count captured by the last snapshot |

## Verification
The snapshot and the counter increment can fall in the same cycle. This happens when `snap` is raised together with the multiframe start bit at a boundary whose previous multiframe carried corrupted check bits. The bench does this at intervals during a sweep of all 64 check-bit corruption patterns. It expects the snapshot to already include that boundary's error, and the following snapshot to count only errors after it. A lost or doubled increment shows as a one-count difference between the two.

// File: rtl/t1crc_pkg.sv
package t1crc_pkg;
  localparam int unsigned CRC_W = 6;
  // generator x^6 + x + 1 without the leading term
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                input logic d);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/crc6_serial.sv
module crc6_serial
  import t1crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             shift,
  input  logic             d,
  output logic [CRC_W-1:0] rem
);
  logic [CRC_W-1:0] rem_d;

  always_comb begin
    rem_d = rem;
    if (clr)        rem_d = '0;
    else if (load)  rem_d = crc_step('0, d);
    else if (shift) rem_d = crc_step(rem, d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem <= '0;
    else        rem <= rem_d;
  end
endmodule

// File: rtl/mf_slot_track.sv
module mf_slot_track
  import t1crc_pkg::*;
#(
  parameter int unsigned FRAMES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vld,
  input  logic             mf_start,
  input  logic             fslot,
  input  logic             d,
  output logic [CRC_W-1:0] chk
);
  localparam int unsigned STEP = FRAMES / CRC_W;
  localparam int unsigned FW   = $clog2(FRAMES + 1);
  localparam logic [FW-1:0] FLAST = FW'(FRAMES);

  logic [FW-1:0]    fcnt, fcnt_d;
  logic [CRC_W-1:0] chk_d;
  logic             is_chk_slot;

  // fcnt holds the 0-based index of the frame whose framing slot comes next
  assign is_chk_slot = ((32'(fcnt) % STEP) == 1);

  always_comb begin
    fcnt_d = fcnt;
    chk_d  = chk;
    if (clr) begin
      fcnt_d = '0;
      chk_d  = '0;
    end else if (vld && mf_start) begin
      fcnt_d = FW'(1);
    end else if (vld && fslot) begin
      if (is_chk_slot)   chk_d  = {chk[CRC_W-2:0], d};
      if (fcnt != FLAST) fcnt_d = fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      chk  <= '0;
    end else begin
      fcnt <= fcnt_d;
      chk  <= chk_d;
    end
  end
endmodule

// File: rtl/err_tally.sv
module err_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             snap,
  output logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] snap_q
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sum, live_d;

  always_comb begin
    sum    = (inc && (live != CMAX)) ? live + 1'b1 : live;
    live_d = snap ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= '0;
    else        live <= live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (snap) snap_q <= sum;
  end
endmodule

// File: rtl/t1_crc6_mf_check.sv
module t1_crc6_mf_check
  import t1crc_pkg::*;
#(
  parameter int unsigned FRAMES = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sync,
  input  logic             chk_en,
  input  logic             crc_fmt,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             mf_start,
  input  logic             fslot,
  input  logic             snap,
  output logic             crc_err,
  output logic [CNT_W-1:0] err_cnt_q
);
  logic             act, start, d_eff, mism;
  logic [CRC_W-1:0] rem, chk, held, held_d;
  logic             running, running_d, held_vld, held_vld_d;
  logic [CNT_W-1:0] err_live;

  assign act   = in_sync & chk_en & crc_fmt;
  assign start = bit_vld & mf_start;
  assign d_eff = fslot | bit_in;   // framing slots enter the CRC as 1

  crc6_serial u_crc (
    .clk(clk), .rst_n(rst_n), .clr(!act), .load(start),
    .shift(bit_vld), .d(d_eff), .rem(rem)
  );

  mf_slot_track #(.FRAMES(FRAMES)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(!act), .vld(bit_vld),
    .mf_start(mf_start), .fslot(fslot), .d(bit_in), .chk(chk)
  );

  err_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .inc(mism), .snap(snap),
    .live(err_live), .snap_q(err_cnt_q)
  );

  assign mism = act & start & held_vld & (held != chk);

  always_comb begin
    running_d  = running;
    held_vld_d = held_vld;
    held_d     = held;
    if (!act) begin
      running_d  = 1'b0;
      held_vld_d = 1'b0;
      held_d     = '0;
    end else if (start) begin
      running_d = 1'b1;
      if (running) begin
        held_d     = rem;
        held_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      held_vld <= 1'b0;
      held     <= '0;
      crc_err  <= 1'b0;
    end else begin
      running  <= running_d;
      held_vld <= held_vld_d;
      held     <= held_d;
      crc_err  <= mism;
    end
  end
endmodule

// File: rtl/t1_crc6_mf_check_sva.sv
module t1_crc6_mf_check_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_sync,
  input logic             chk_en,
  input logic             crc_fmt,
  input logic             bit_vld,
  input logic             mf_start,
  input logic             snap,
  input logic             crc_err,
  input logic [CNT_W-1:0] err_cnt_q,
  input logic [CNT_W-1:0] err_live
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_pulse_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_vld && mf_start) |=> !crc_err);

  p_quiet_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_sync && chk_en && crc_fmt) |=> !crc_err);

  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_live == CMAX && !snap) |=> err_live == CMAX);

  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> (err_live == $past(err_live) || err_live == $past(err_live) + 1'b1));

  p_snap_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> err_live == '0);

  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(err_cnt_q));
endmodule

bind t1_crc6_mf_check t1_crc6_mf_check_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .chk_en(chk_en),
  .crc_fmt(crc_fmt), .bit_vld(bit_vld), .mf_start(mf_start), .snap(snap),
  .crc_err(crc_err), .err_cnt_q(err_cnt_q), .err_live(err_live)
);

// File: tb/test_t1_crc6_mf_check.sv
module test_t1_crc6_mf_check;
  localparam int CLK_T  = 10;
  localparam int FRAMES = 24;
  localparam int CNT_W  = 4;
  localparam int BPF    = 3;               // short frames: 1 framing + 2 data bits
  localparam int NB     = FRAMES * BPF;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam logic [6:0] GEN = 7'b1000011; // x^6 + x + 1

  logic clk, rst_n, in_sync, chk_en, crc_fmt, bit_vld, bit_in, mf_start, fslot, snap;
  logic crc_err;
  logic [CNT_W-1:0] err_cnt_q;

  t1_crc6_mf_check #(.FRAMES(FRAMES), .CNT_W(CNT_W)) i_t1_crc6_mf_check (
    .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .chk_en(chk_en), .crc_fmt(crc_fmt),
    .bit_vld(bit_vld), .bit_in(bit_in), .mf_start(mf_start), .fslot(fslot),
    .snap(snap), .crc_err(crc_err), .err_cnt_q(err_cnt_q)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  bit   act_b = 0;
  int   mf_idx = 0;
  logic [5:0] last_mask = '0, prev_rem = '0;
  int   exp_cnt = 0;

  initial clk = 0;
  always #(CLK_T/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  function automatic logic lcg_bit();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[16];
  endfunction

  // polynomial long division of msg * x^6 by the generator
  function automatic logic [5:0] ref_rem(input logic [0:NB-1] m);
    logic [0:NB+5] a;
    a = {m, 6'b0};
    for (int i = 0; i < NB; i++)
      if (a[i])
        for (int k = 0; k <= 6; k++) a[i+k] = a[i+k] ^ GEN[6-k];
    return a[NB +: 6];
  endfunction

  task automatic idle_set(input logic s, input logic e, input logic f);
    @(negedge clk);
    bit_vld = 0; mf_start = 0; fslot = 0; snap = 0;
    in_sync = s; chk_en = e; crc_fmt = f;
    act_b = s & e & f;
    if (!act_b) begin
      mf_idx = 0; last_mask = '0; prev_rem = '0;
    end
  endtask

  task automatic drive(input logic b, input int pos, input logic sn);
    bit_vld = 1; bit_in = b; mf_start = (pos == 0); fslot = (pos % BPF == 0); snap = sn;
  endtask

  task automatic send_mf(input logic [5:0] mask, input bit do_snap, input int gap);
    logic [0:NB-1] raw, eff;
    logic [5:0] chkb;
    bit exp_err;
    int exp_snap;
    chkb = prev_rem ^ mask;
    for (int i = 0; i < NB; i++) begin
      if (i % BPF == 0) begin
        int fr;
        fr = i / BPF;
        raw[i] = (fr % 4 == 1) ? chkb[5 - fr/4] : lcg_bit();  // R2 slots
        eff[i] = 1'b1;
      end else begin
        raw[i] = lcg_bit();
        eff[i] = raw[i];
      end
    end
    exp_err = act_b && (mf_idx >= 2) && (last_mask != 0);
    if (exp_err && exp_cnt < CMAX) exp_cnt++;
    exp_snap = exp_cnt;
    @(negedge clk);
    drive(raw[0], 0, do_snap);
    for (int i = 1; i < NB; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check(crc_err == exp_err, "R3/R4/R5 boundary pulse", crc_err, exp_err);
        if (do_snap) begin
          check(err_cnt_q == exp_snap, "R8 snapshot with same-cycle increment", err_cnt_q, exp_snap);
          exp_cnt = 0;
        end
      end
      if (i == 2) check(crc_err == 0, "R3 single-cycle pulse", crc_err, 0);
      if (gap != 0 && i >= 2 && i % gap == 0) begin
        bit_vld = 0; bit_in = lcg_bit(); mf_start = 1; fslot = 1; snap = 0;  // R6 ignored
        @(negedge clk);
      end
      drive(raw[i], i, 1'b0);
    end
    if (act_b) begin
      prev_rem = ref_rem(eff);   // R1 reference remainder
      last_mask = mask;
      mf_idx++;
    end
  endtask

  task automatic snap_check(input string req);
    @(negedge clk);
    bit_vld = 0; mf_start = 0; fslot = 0; snap = 1;
    @(negedge clk);
    snap = 0;
    check(err_cnt_q == exp_cnt, req, err_cnt_q, exp_cnt);
    exp_cnt = 0;
  endtask

  initial begin
    rst_n = 0; in_sync = 0; chk_en = 0; crc_fmt = 0;
    bit_vld = 0; bit_in = 0; mf_start = 0; fslot = 0; snap = 0;
    repeat (3) @(negedge clk);
    check(crc_err == 0, "R9 reset pulse", crc_err, 0);
    check(err_cnt_q == 0, "R9 reset count", err_cnt_q, 0);
    rst_n = 1;

    // sweep all corruption patterns; snapshots land on boundaries (R1 R2 R3 R6 R7 R8)
    idle_set(1, 1, 1);
    send_mf(6'h00, 0, 0);
    send_mf(6'h15, 0, 0);  // checked at third boundary (R4)
    for (int m = 0; m < 64; m++)
      send_mf(6'(m), (m % 24 == 23), (m % 3 == 0) ? 5 : 0);
    send_mf(6'h00, 0, 0);
    snap_check("R7/R8 count after sweep");

    // inactive conditions: bad check bits counted nowhere (R5)
    idle_set(1, 0, 1);
    for (int k = 0; k < 3; k++) send_mf(6'h3F, 0, 0);
    snap_check("R5 disabled no count");
    idle_set(1, 1, 0);
    for (int k = 0; k < 3; k++) send_mf(6'h3F, 0, 0);
    snap_check("R5 no-CRC format no count");
    idle_set(0, 1, 1);
    for (int k = 0; k < 3; k++) send_mf(6'h3F, 0, 0);
    snap_check("R5 out of sync no count");

    // reactivate: first two boundaries silent, third compares (R4)
    idle_set(1, 1, 1);
    send_mf(6'h3F, 0, 0);
    send_mf(6'h3F, 0, 0);
    send_mf(6'h01, 0, 0);
    send_mf(6'h00, 0, 0);

    // loss of sync discards history (R5)
    idle_set(0, 1, 1);
    idle_set(1, 1, 1);
    send_mf(6'h20, 0, 0);
    send_mf(6'h04, 0, 0);
    send_mf(6'h00, 0, 0);
    send_mf(6'h00, 0, 0);
    snap_check("R4/R5 count after resync");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule